// File: doc/BRIEF.md
# I2C Slave Address Recognizer

This block decides whether the first byte seen on the bus after a START (or a repeated START) selects this device. The byte is compared against a programmable own-address register. The upper seven bits of that register hold the slave address. Its lowest bit decides whether the general call address 00H is accepted.

The byte framing logic reports bus events to the block as single-cycle strobes: START seen, STOP seen, and byte received. On the byte received strobe the block also takes the byte itself, and the byte's most significant bit is the first bit that came off the wire after START. The block then drives registered match indications that stay in place until the next START or STOP. When the module is disabled or the controller is acting as a bus master, it behaves as a slave that has not been addressed and ignores all bus events. The block only reads the own-address register and never writes it.

Top module: `slave_addr_recognizer`

## Requirements
- R1: After reset, addrMatch, genCallMatch and readDir are all 0.
- R2: The first byte strobed after START sets addrMatch on the clock edge that samples the strobe, but only when the byte's upper seven bits equal ownAddr[7:1] and are not all zero.
- R3: readDir equals bit 0 of the matched byte (1 = read) while addrMatch is 1, and is 0 whenever addrMatch is 0.
- R4: A first byte of exactly 00H sets genCallMatch only when ownAddr[0] is 1. When ownAddr[0] is 0, that byte leaves every output at 0.
- R5: A first byte of 01H (address zero with the read bit set) matches nothing, whatever ownAddr holds.
- R6: Only the first byte after a START is compared. Later bytes leave the outputs unchanged until the next START or STOP.
- R7: A STOP clears all outputs on the next edge. Bytes that arrive after a STOP and before a new START have no effect.
- R8: A START, including a repeated START, clears all outputs on the next edge and arms the block to compare the next byte.
- R9: While enable is 0, all outputs are 0 from the next edge onward, and START strobes and byte strobes are ignored.
- R10: While masterMode is 1, all outputs are 0 from the next edge onward, and the own-address register has no effect.
- R11: A byte strobe that arrives in the same cycle as a START is ignored. The byte that follows it is the one that gets compared.
- R12: addrMatch and genCallMatch are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Module enable; 0 forces the not-addressed state |
| masterMode | input | 1 | Controller is acting as bus master |
| ownAddr | input | 8 | Bits 7:1 own slave address, bit 0 general call enable |
| startSeen | input | 1 | One-cycle pulse on START or repeated START |
| stopSeen | input | 1 | One-cycle pulse on STOP |
| byteValid | input | 1 | One-cycle pulse when rxByte holds a complete byte |
| rxByte | input | 8 | Received byte, bit 7 first on the wire |
| addrMatch | output | 1 | Own address recognized |
| genCallMatch | output | 1 | General call recognized |
| readDir | output | 1 | Direction of the matched transfer, 1 = read |

## Verification
The match assertions assume that rxByte and ownAddr are stable in the cycle in which byteValid is sampled. The bench enforces this by changing those inputs only on falling edges, together with the strobe. The hold assertion assumes that bus events arrive only as strobes lasting one cycle. The bench raises each strobe for exactly one clock and then lowers it. It produces simultaneous START and byte strobes only in the dedicated R11 case.

// File: rtl/addr_recog_pkg.sv
package addr_recog_pkg;
  typedef struct packed {
    logic load;   // latch the comparison result
    logic clear;  // drop every indication
  } ctlStrobes_t;
endpackage

// File: rtl/addr_recog_ctrl.sv
module addr_recog_ctrl
  import addr_recog_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic        masterMode,
  input  logic        startSeen,
  input  logic        stopSeen,
  input  logic        byteValid,
  output ctlStrobes_t ctl
);
  logic armed;
  logic active;

  assign active = enable && !masterMode;

  always_comb begin
    ctl.clear = !active || startSeen || stopSeen;
    ctl.load  = active && armed && byteValid && !startSeen && !stopSeen;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              armed <= 1'b0;
    else if (!active)       armed <= 1'b0;
    else if (startSeen)     armed <= 1'b1;
    else if (stopSeen)      armed <= 1'b0;
    else if (byteValid)     armed <= 1'b0;
  end
endmodule

// File: rtl/addr_recog_dp.sv
module addr_recog_dp
  import addr_recog_pkg::*;
#(
  parameter int ADDR_BITS = 7,
  localparam int BYTE_W = ADDR_BITS + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       ctl,
  input  logic [BYTE_W-1:0] ownAddr,
  input  logic [BYTE_W-1:0] rxByte,
  output logic              addrMatch,
  output logic              genCallMatch,
  output logic              readDir
);
  logic ownHit;
  logic gcHit;
  logic addrNonZero;

  assign addrNonZero = |rxByte[BYTE_W-1:1];
  assign ownHit = addrNonZero && (rxByte[BYTE_W-1:1] == ownAddr[BYTE_W-1:1]);
  assign gcHit  = ownAddr[0] && (rxByte == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrMatch    <= 1'b0;
      genCallMatch <= 1'b0;
      readDir      <= 1'b0;
    end else if (ctl.clear) begin
      addrMatch    <= 1'b0;
      genCallMatch <= 1'b0;
      readDir      <= 1'b0;
    end else if (ctl.load) begin
      addrMatch    <= ownHit;
      genCallMatch <= gcHit;
      readDir      <= ownHit && rxByte[0];
    end
  end
endmodule

// File: rtl/slave_addr_recognizer.sv
module slave_addr_recognizer
  import addr_recog_pkg::*;
#(
  parameter int ADDR_BITS = 7,
  localparam int BYTE_W = ADDR_BITS + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              masterMode,
  input  logic [BYTE_W-1:0] ownAddr,
  input  logic              startSeen,
  input  logic              stopSeen,
  input  logic              byteValid,
  input  logic [BYTE_W-1:0] rxByte,
  output logic              addrMatch,
  output logic              genCallMatch,
  output logic              readDir
);
  ctlStrobes_t ctl;

  addr_recog_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .masterMode(masterMode),
    .startSeen(startSeen), .stopSeen(stopSeen), .byteValid(byteValid),
    .ctl(ctl)
  );

  addr_recog_dp #(.ADDR_BITS(ADDR_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .ownAddr(ownAddr), .rxByte(rxByte),
    .addrMatch(addrMatch), .genCallMatch(genCallMatch), .readDir(readDir)
  );
endmodule

// File: rtl/addr_recog_checker.sv
module addr_recog_checker #(
  parameter int ADDR_BITS = 7,
  localparam int BYTE_W = ADDR_BITS + 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              enable,
  input logic              masterMode,
  input logic [BYTE_W-1:0] ownAddr,
  input logic              startSeen,
  input logic              stopSeen,
  input logic              byteValid,
  input logic [BYTE_W-1:0] rxByte,
  input logic              addrMatch,
  input logic              genCallMatch,
  input logic              readDir
);
  a_r12_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(addrMatch && genCallMatch));

  a_r3_dir_needs_match: assert property (@(posedge clk) disable iff (!rstN)
    readDir |-> addrMatch);

  a_r7_stop_clears: assert property (@(posedge clk) disable iff (!rstN)
    stopSeen |=> (!addrMatch && !genCallMatch && !readDir));

  a_r8_start_clears: assert property (@(posedge clk) disable iff (!rstN)
    startSeen |=> (!addrMatch && !genCallMatch));

  a_r9_disabled_idle: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!addrMatch && !genCallMatch && !readDir));

  a_r10_master_idle: assert property (@(posedge clk) disable iff (!rstN)
    masterMode |=> (!addrMatch && !genCallMatch && !readDir));

  a_r2_match_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(addrMatch) |-> ($past(byteValid) &&
      ($past(rxByte[BYTE_W-1:1]) == $past(ownAddr[BYTE_W-1:1]))));

  a_r4_gc_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(genCallMatch) |-> ($past(byteValid) && $past(ownAddr[0]) &&
      ($past(rxByte) == '0)));

  a_r6_hold: assert property (@(posedge clk) disable iff (!rstN)
    (addrMatch && enable && !masterMode && !startSeen && !stopSeen)
      |=> addrMatch);
endmodule

bind slave_addr_recognizer addr_recog_checker #(.ADDR_BITS(ADDR_BITS)) u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .masterMode(masterMode),
  .ownAddr(ownAddr), .startSeen(startSeen), .stopSeen(stopSeen),
  .byteValid(byteValid), .rxByte(rxByte), .addrMatch(addrMatch),
  .genCallMatch(genCallMatch), .readDir(readDir)
);

// File: tb/sim_slave_addr_recognizer.sv
module sim_slave_addr_recognizer;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic masterMode = 1'b0;
  logic [7:0] ownAddr = 8'h00;
  logic startSeen = 1'b0;
  logic stopSeen = 1'b0;
  logic byteValid = 1'b0;
  logic [7:0] rxByte = 8'h00;
  logic addrMatch, genCallMatch, readDir;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  slave_addr_recognizer u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .masterMode(masterMode),
    .ownAddr(ownAddr), .startSeen(startSeen), .stopSeen(stopSeen),
    .byteValid(byteValid), .rxByte(rxByte), .addrMatch(addrMatch),
    .genCallMatch(genCallMatch), .readDir(readDir)
  );

  task automatic expect3(string req, logic em, logic eg, logic ed);
    checks++;
    if ({addrMatch, genCallMatch, readDir} !== {em, eg, ed}) begin
      errors++;
      $display("FAIL %s: got m/g/d=%b%b%b expected %b%b%b (own=%h)",
               req, addrMatch, genCallMatch, readDir, em, eg, ed, ownAddr);
    end
  endtask

  task automatic pulseStart();
    @(negedge clk); startSeen = 1'b1;
    @(negedge clk); startSeen = 1'b0;
  endtask

  task automatic pulseStop();
    @(negedge clk); stopSeen = 1'b1;
    @(negedge clk); stopSeen = 1'b0;
  endtask

  task automatic sendByte(logic [7:0] b);
    @(negedge clk); byteValid = 1'b1; rxByte = b;
    @(negedge clk); byteValid = 1'b0;
  endtask

  initial begin
    logic em, eg, ed;
    repeat (3) @(negedge clk);
    expect3("R1", 0, 0, 0);
    rstN = 1'b1;
    enable = 1'b1;
    @(negedge clk);
    expect3("R1", 0, 0, 0);

    // R2 R3 R4 R5 R12: sweep every first byte against several own addresses
    foreach (ownAddr[i]) begin end
    for (int a = 0; a < 8; a++) begin
      logic [7:0] oa;
      case (a)
        0: oa = 8'h00; 1: oa = 8'h01; 2: oa = 8'h54; 3: oa = 8'h55;
        4: oa = 8'hFE; 5: oa = 8'hFF; 6: oa = 8'h02; default: oa = 8'hA5;
      endcase
      ownAddr = oa;
      for (int b = 0; b < 256; b++) begin
        pulseStart();
        expect3("R8", 0, 0, 0);
        sendByte(8'(b));
        em = (8'(b) >> 1) == (oa >> 1) && (8'(b) >> 1) != 0;
        eg = oa[0] && (b == 0);
        ed = em && b[0];
        if (b == 1) expect3("R5", em, eg, ed);
        else if (b == 0) expect3("R4", em, eg, ed);
        else expect3("R2_R3_R12", em, eg, ed);
      end
    end

    // R6: later bytes do not change the outputs
    ownAddr = 8'h54;
    pulseStart(); sendByte(8'h55);
    expect3("R6", 1, 0, 1);
    sendByte(8'h00); expect3("R6", 1, 0, 1);
    sendByte(8'h12); expect3("R6", 1, 0, 1);
    pulseStart(); sendByte(8'h12);
    expect3("R6", 0, 0, 0);
    sendByte(8'h54); expect3("R6", 0, 0, 0);

    // R7: STOP clears and disarms
    pulseStart(); sendByte(8'h54); expect3("R7", 1, 0, 0);
    pulseStop(); expect3("R7", 0, 0, 0);
    sendByte(8'h54); expect3("R7", 0, 0, 0);

    // R8: repeated START clears and rearms
    pulseStart(); sendByte(8'h55); expect3("R8", 1, 0, 1);
    pulseStart(); expect3("R8", 0, 0, 0);
    sendByte(8'h54); expect3("R8", 1, 0, 0);

    // R11: byte together with START is ignored
    pulseStop();
    @(negedge clk); startSeen = 1'b1; byteValid = 1'b1; rxByte = 8'h54;
    @(negedge clk); startSeen = 1'b0; byteValid = 1'b0;
    expect3("R11", 0, 0, 0);
    sendByte(8'h55); expect3("R11", 1, 0, 1);

    // R9: disable clears and ignores events
    @(negedge clk); enable = 1'b0;
    @(negedge clk); expect3("R9", 0, 0, 0);
    pulseStart(); sendByte(8'h54); expect3("R9", 0, 0, 0);
    @(negedge clk); enable = 1'b1;
    sendByte(8'h54); expect3("R9", 0, 0, 0);
    ownAddr = 8'h01;
    pulseStart(); sendByte(8'h00); expect3("R4", 0, 1, 0);
    @(negedge clk); enable = 1'b0;
    @(negedge clk); expect3("R9", 0, 0, 0);
    enable = 1'b1;

    // R10: master mode clears and ignores the own address
    ownAddr = 8'h54;
    pulseStart(); sendByte(8'h54); expect3("R10", 1, 0, 0);
    @(negedge clk); masterMode = 1'b1;
    @(negedge clk); expect3("R10", 0, 0, 0);
    pulseStart(); sendByte(8'h54); expect3("R10", 0, 0, 0);
    ownAddr = 8'h01;
    pulseStart(); sendByte(8'h00); expect3("R10", 0, 0, 0);
    @(negedge clk); masterMode = 1'b0;
    sendByte(8'h00); expect3("R10", 0, 0, 0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule